// File: doc/BRIEF.md
# Daisy-Chain Device Select Logic

This block gives one device in a daisy chain its identity and decides whether the device is being addressed. It holds two 16-bit registers. The page register is the device's own address within the chain. The target register names the device that the host wants to reach. The device counts as addressed when the two registers hold the same value. An all-ones target value addresses every device in the chain at once.

The host loads a register in two steps. It first issues a target command that names the register, and then issues a command write that carries the value. A command write consumes the pending target, so a write without a preceding target command changes nothing. An all-ones page address is illegal. A write of that value is refused and raises a one-clock error pulse. When the device is addressed only through the all-ones broadcast value, it drives no read data on either read path.

A hardware reset clears both registers. A software reset keeps both registers and discards only a pending target command.

Top module: `chain_select`

## Requirements
- R1: After hardware reset, both registers read as zero. The block is therefore addressed (`dev_sel`=1), `bcast`=0, and a command read returns 0x0000.
- R2: A target command (`tgt_valid`=1) with `tgt_sel`=0 names the page register, and with `tgt_sel`=1 names the target register. The next command write (`wr_valid`=1) loads `wr_data` into the named register at that clock edge.
- R3: A write of 0xFFFF aimed at the page register is refused, and the page register keeps its previous value.
- R4: `pa_err` is 1 for exactly the one cycle that follows the edge at which an illegal page write is refused. It is 0 at all other times.
- R5: A command write with no pending target changes neither register. One target command enables exactly one write.
- R6: `dev_sel` is 1 when the target register equals the page register or equals 0xFFFF. `bcast` is 1 exactly when the target register is 0xFFFF. Both outputs follow a register load in the cycle after it.
- R7: `cmd_rd_oe` = `cmd_rd_req` AND `dev_sel` AND NOT `bcast`. While `cmd_rd_oe` is 1, `cmd_rd_data` carries the target register. Otherwise `cmd_rd_data` is 0x0000.
- R8: `data_rd_oe` = `data_rd_req` AND `dev_sel` AND NOT `bcast`, so no read data is driven while the device is reached only by broadcast.
- R9: A software reset (`sw_rst`=1) leaves both registers unchanged. It discards a pending target, and it ignores any target command or write presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low. It asserts asynchronously and releases synchronously. |
| sw_rst | input | 1 | Software reset strobe |
| tgt_valid | input | 1 | Target command strobe |
| tgt_sel | input | 1 | Register named by the target command: 0 = page, 1 = target |
| wr_valid | input | 1 | Command write strobe |
| wr_data | input | 16 | Command write value |
| cmd_rd_req | input | 1 | Command read request for the target register |
| data_rd_req | input | 1 | Data read request |
| dev_sel | output | 1 | Device is addressed |
| bcast | output | 1 | Target register holds the all-ones broadcast value |
| pa_err | output | 1 | One-cycle pulse after an illegal page write is refused |
| cmd_rd_data | output | 16 | Target register readback, zero when not enabled |
| cmd_rd_oe | output | 1 | Command read data is being driven |
| data_rd_oe | output | 1 | Data read output is enabled |

## Verification
A corrupted pending-target bit shows at the ports in the cycle after the next command write. Either a stray write moves `dev_sel` or the `cmd_rd_data` readback, or an intended load fails to appear. A page register that accepts all-ones, or an error flag stuck on, shows on `pa_err` and `dev_sel` one cycle after the write. A wrong broadcast decode appears at once on `cmd_rd_oe` and `data_rd_oe` while a read request is held. A software reset that disturbs the registers changes the readback on the following cycle.

// File: rtl/chain_sel_pkg.sv
package chain_sel_pkg;
  typedef enum logic {
    TGT_PAGE = 1'b0,
    TGT_DSEL = 1'b1
  } tgt_sel_e;
endpackage

// File: rtl/chain_sel_rstsync.sv
module chain_sel_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/chain_sel_cmd.sv
module chain_sel_cmd
  import chain_sel_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_rst,
  input  logic         tgt_valid,
  input  logic         tgt_sel,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         pa_ld,
  output logic         ds_ld,
  output logic [W-1:0] ld_data,
  output logic         pa_err
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic     pend_q, pend_d;
  tgt_sel_e pend_sel_q, pend_sel_d;
  logic     err_q, err_d;
  logic     consume;
  logic     page_rej;

  always_comb begin
    consume  = wr_valid && pend_q && !sw_rst;
    pa_ld    = consume && (pend_sel_q == TGT_PAGE) && (wr_data != ALL_ONES);
    page_rej = consume && (pend_sel_q == TGT_PAGE) && (wr_data == ALL_ONES);
    ds_ld    = consume && (pend_sel_q == TGT_DSEL);
    ld_data  = wr_data;
    err_d    = page_rej;

    pend_d     = pend_q;
    pend_sel_d = pend_sel_q;
    if (sw_rst) begin
      pend_d = 1'b0;
    end else if (tgt_valid) begin
      pend_d     = 1'b1;
      pend_sel_d = tgt_sel_e'(tgt_sel);
    end else if (consume) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_sel_q <= TGT_PAGE;
      err_q      <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      pend_sel_q <= pend_sel_d;
      err_q      <= err_d;
    end
  end

  assign pa_err = err_q;

  // R4: the error flag never lasts two cycles
  p_err_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pa_err |=> !pa_err);

  // R5: a write with nothing pending loads neither register
  p_stray_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !pend_q) |-> (!pa_ld && !ds_ld));

  // R5: a write consumes the pending target
  p_pend_consumed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && pend_q && !tgt_valid) |=> !pend_q);
endmodule

// File: rtl/chain_sel_regs.sv
module chain_sel_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pa_ld,
  input  logic         ds_ld,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] pa_q,
  output logic [W-1:0] ds_q
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] pa_d, ds_d;

  always_comb begin
    pa_d = pa_ld ? ld_data : pa_q;
    ds_d = ds_ld ? ld_data : ds_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= '0;
      ds_q <= '0;
    end else begin
      pa_q <= pa_d;
      ds_q <= ds_d;
    end
  end

  // R3: the page register never holds the illegal value
  p_pa_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pa_q != ALL_ONES);
endmodule

// File: rtl/chain_sel_cmp.sv
module chain_sel_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] pa_q,
  input  logic [W-1:0] ds_q,
  input  logic         cmd_rd_req,
  input  logic         data_rd_req,
  output logic         dev_sel,
  output logic         bcast,
  output logic [W-1:0] cmd_rd_data,
  output logic         cmd_rd_oe,
  output logic         data_rd_oe
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic exact;
  logic rd_ok;

  always_comb begin
    exact       = (ds_q == pa_q);
    bcast       = (ds_q == ALL_ONES);
    dev_sel     = exact || bcast;
    rd_ok       = dev_sel && !bcast;
    cmd_rd_oe   = cmd_rd_req && rd_ok;
    data_rd_oe  = data_rd_req && rd_ok;
    cmd_rd_data = cmd_rd_oe ? ds_q : '0;
  end
endmodule

// File: rtl/chain_select.sv
module chain_select
  import chain_sel_pkg::*;
#(
  parameter int W          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_rst,
  input  logic         tgt_valid,
  input  logic         tgt_sel,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         cmd_rd_req,
  input  logic         data_rd_req,
  output logic         dev_sel,
  output logic         bcast,
  output logic         pa_err,
  output logic [W-1:0] cmd_rd_data,
  output logic         cmd_rd_oe,
  output logic         data_rd_oe
);
  logic         rst_n_s;
  logic         pa_ld, ds_ld;
  logic [W-1:0] ld_data;
  logic [W-1:0] pa_q, ds_q;

  chain_sel_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  chain_sel_cmd #(.W(W)) u_cmd (
    .clk(clk), .rst_n(rst_n_s), .sw_rst(sw_rst),
    .tgt_valid(tgt_valid), .tgt_sel(tgt_sel),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .pa_ld(pa_ld), .ds_ld(ds_ld), .ld_data(ld_data), .pa_err(pa_err)
  );

  chain_sel_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .pa_ld(pa_ld), .ds_ld(ds_ld),
    .ld_data(ld_data), .pa_q(pa_q), .ds_q(ds_q)
  );

  chain_sel_cmp #(.W(W)) u_cmp (
    .pa_q(pa_q), .ds_q(ds_q),
    .cmd_rd_req(cmd_rd_req), .data_rd_req(data_rd_req),
    .dev_sel(dev_sel), .bcast(bcast), .cmd_rd_data(cmd_rd_data),
    .cmd_rd_oe(cmd_rd_oe), .data_rd_oe(data_rd_oe)
  );

  // R9: a software reset leaves both registers as they were
  p_sw_keep_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    sw_rst |=> ($stable(pa_q) && $stable(ds_q)));

  // R8: broadcast-only selection drives no read data
  p_bcast_mute_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    bcast |-> (!cmd_rd_oe && !data_rd_oe));

  // R6: a broadcast target always selects the device
  p_bcast_sel_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    bcast |-> dev_sel);
endmodule

// File: tb/chain_select_bench.sv
module chain_select_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sw_rst = 1'b0, tgt_valid = 1'b0, tgt_sel = 1'b0, wr_valid = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         cmd_rd_req = 1'b0, data_rd_req = 1'b0;
  logic         dev_sel, bcast, pa_err, cmd_rd_oe, data_rd_oe;
  logic [W-1:0] cmd_rd_data;

  chain_select u_chain_select (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .tgt_valid(tgt_valid),
    .tgt_sel(tgt_sel), .wr_valid(wr_valid), .wr_data(wr_data),
    .cmd_rd_req(cmd_rd_req), .data_rd_req(data_rd_req),
    .dev_sel(dev_sel), .bcast(bcast), .pa_err(pa_err),
    .cmd_rd_data(cmd_rd_data), .cmd_rd_oe(cmd_rd_oe), .data_rd_oe(data_rd_oe)
  );

  always #5 clk = ~clk;

  typedef struct {
    string        tag;
    logic         sel;
    logic         bc;
    logic         err;
    logic         roe;
    logic [W-1:0] rdat;
    logic         doe;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc   = 0;

  // reference model state
  logic [W-1:0] m_pa = '0, m_ds = '0;
  logic         m_pend = 1'b0, m_psel = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (dev_sel !== e.sel || bcast !== e.bc || pa_err !== e.err ||
          cmd_rd_oe !== e.roe || cmd_rd_data !== e.rdat || data_rd_oe !== e.doe) begin
        n_bad++;
        $display("FAIL %s: got sel=%b bc=%b err=%b roe=%b rd=%h doe=%b exp sel=%b bc=%b err=%b roe=%b rd=%h doe=%b",
                 e.tag, dev_sel, bcast, pa_err, cmd_rd_oe, cmd_rd_data, data_rd_oe,
                 e.sel, e.bc, e.err, e.roe, e.rdat, e.doe);
      end
    end
    if (cyc > 5000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic step(input string tag, input logic tv, input logic ts,
                      input logic wv, input logic [W-1:0] wd, input logic sr,
                      input logic crd, input logic drd);
    exp_t e;
    logic rej;
    logic cons;
    @(negedge clk);
    #2;
    tgt_valid = tv; tgt_sel = ts; wr_valid = wv; wr_data = wd;
    sw_rst = sr; cmd_rd_req = crd; data_rd_req = drd;
    @(posedge clk);
    #1;
    tgt_valid = 1'b0; wr_valid = 1'b0; sw_rst = 1'b0;
    // model update from requirements R2, R3, R5, R9
    rej  = 1'b0;
    cons = wv && m_pend && !sr;
    if (cons) begin
      if (m_psel == 1'b1) m_ds = wd;
      else if (wd == '1) rej = 1'b1;
      else m_pa = wd;
    end
    if (sr) m_pend = 1'b0;
    else if (tv) begin m_pend = 1'b1; m_psel = ts; end
    else if (cons) m_pend = 1'b0;
    // expected outputs, R6 to R8 and R4
    e.tag  = tag;
    e.bc   = (m_ds == '1);
    e.sel  = (m_ds == m_pa) || e.bc;
    e.err  = rej;
    e.roe  = crd && e.sel && !e.bc;
    e.rdat = e.roe ? m_ds : '0;
    e.doe  = drd && e.sel && !e.bc;
    exp_q.push_back(e);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_pa = '0; m_ds = '0; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    hw_reset();
    // R1: reset state
    step("R1 reset state", 0, 0, 0, '0, 0, 1, 1);
    // R5: stray write
    step("R5 stray write", 0, 0, 1, 16'h1234, 0, 1, 0);
    // R2/R6: load target register
    step("R2 target cmd dsel", 1, 1, 0, '0, 0, 0, 0);
    step("R2 R6 load dsel", 0, 0, 1, 16'h00A5, 0, 1, 1);
    // R2/R7: load page register to match
    step("R2 target cmd page", 1, 0, 0, '0, 0, 0, 0);
    step("R2 R7 load page match", 0, 0, 1, 16'h00A5, 0, 1, 1);
    // R5: one target enables exactly one write
    step("R5 second write ignored", 0, 0, 1, 16'h0011, 0, 1, 0);
    // R3/R4: illegal page write
    step("R3 target page", 1, 0, 0, '0, 0, 0, 0);
    step("R3 R4 illegal page", 0, 0, 1, 16'hFFFF, 0, 1, 0);
    step("R4 err cleared", 0, 0, 0, '0, 0, 1, 1);
    // R6/R7/R8: broadcast
    step("R6 target dsel", 1, 1, 0, '0, 0, 0, 0);
    step("R6 R7 R8 broadcast", 0, 0, 1, 16'hFFFF, 0, 1, 1);
    // R9: software reset keeps regs
    step("R9 sw reset keeps", 0, 0, 0, '0, 1, 1, 1);
    step("R9 target before sw", 1, 1, 0, '0, 0, 0, 0);
    step("R9 sw reset drops pend", 0, 0, 0, '0, 1, 0, 0);
    step("R9 write after sw ignored", 0, 0, 1, 16'h00A5, 0, 1, 1);
    step("R9 target with sw", 1, 1, 0, '0, 1, 0, 0);
    step("R9 write same as sw", 0, 0, 1, 16'h00A5, 1, 0, 0);
    // R8: exact match enables data read
    step("R8 target dsel", 1, 1, 0, '0, 0, 0, 0);
    step("R8 R7 match read", 0, 0, 1, 16'h00A5, 0, 1, 1);
    step("R8 mismatch read", 1, 1, 0, '0, 0, 0, 1);
    step("R8 R6 mismatch", 0, 0, 1, 16'h0001, 0, 1, 1);
    // R1: hardware reset clears both
    hw_reset();
    step("R1 hw reset clears", 0, 0, 0, '0, 0, 1, 1);
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule